// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is the control core of an SPI master. It decides when a frame is launched, whether the next frame follows it, and when the interface goes back to rest. The bit shifter is outside the block. It receives a one-cycle launch strobe and reports back with a one-cycle done pulse. The block drives four active-low chip selects and a force-idle signal that parks the serial clock and the transmit line. It also drives a busy flag that guards the settings.

The settings are as follows:
- A link mode: full duplex, transmit only or receive only.
- A transfer kind: single frame, counted burst or continuous stream.
- A burst length.
- A chip-select index.

Software enables the peripheral, writes the settings and then raises the transfer enable. In the two modes that transmit, a frame also needs a data-written event. It does not matter whether that event comes before or after the enable.

The state machine has four states:
- `ST_IDLE`: the lines are at rest and no select is active.
- `ST_LAUNCH`: the one-cycle launch strobe is issued.
- `ST_SHIFT`: a frame is in flight.
- `ST_HOLD`: the select stays asserted between frames.

The transitions are:
- IDLE→LAUNCH (start): when the enable is high and the mode's data condition is met.
- LAUNCH→SHIFT: always.
- SHIFT→IDLE (end): on frame done for a single frame, a final burst frame, or a cleared enable.
- SHIFT→HOLD (next): on frame done when more frames may follow.
- HOLD→LAUNCH (resume): when the data condition holds.
- HOLD→IDLE (stop): when the enable is cleared.
- Any state→IDLE (kill): when the peripheral enable is low.

Top module: `spi_xfer_seq`

## Requirements
- R1: After reset, `cs_n` is 4'b1111, `line_idle` is 1, `frame_start` is 0 and `cfg_busy` is 0.
- R2: A settings write (`cfg_wr`) is taken only while `periph_en` is 1 and `cfg_busy` is 0. A write made while `periph_en` is 0 or while `cfg_busy` is 1 leaves the settings unchanged. This is seen through the chip select chosen on the next frame.
- R3: An accepted settings write raises `cfg_busy` at the next clock edge. The flag stays 1 for at least 2 cycles and clears only when the sequencer is idle.
- R4: In full duplex (`cfg_mode`=2'b00, 2'b11 behaves the same) and transmit mode (2'b01), a frame is launched once `xfer_en` is 1 and a `tx_wr` pulse has been seen, in either order. If the data was written first, `frame_start` rises one cycle after `xfer_en` rises. Without a data write, no frame starts.
- R5: In receive mode (`cfg_mode`=2'b10), `frame_start` rises one cycle after `xfer_en` rises, with no data write.
- R6: Clearing `xfer_en` during a frame keeps the chip select asserted until `frame_done` arrives.
- R7: When a transfer stops, `cs_n` returns to 4'b1111 and `line_idle` to 1 in the cycle after the final `frame_done`.
- R8: In burst mode (`cfg_kind`=2'b01), a length field L gives exactly L+1 frames. The chip select is held between them. After the last frame the sequencer goes idle.
- R9: A burst stopped before its last frame starts again from its first frame when `xfer_en` is raised again. The full L+1 frames follow.
- R10: In continuous mode (`cfg_kind`=2'b10 or 2'b11), frames follow each other while `xfer_en` is 1 and, in the transmit modes, while data has been written. Otherwise the sequencer waits with the chip select held and launches nothing.
- R11: When `periph_en` is 0, the sequencer is idle after the next clock edge, and any pending data-written event is discarded.
- R12: At most one `cs_n` bit is low. The low bit is the one at the index in `cfg_cs`, and it is low from the launch strobe until the transfer ends.
- R13: `frame_start` lasts exactly one cycle. A `frame_done` outside a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; 0 forces idle |
| xfer_en | input | 1 | Transfer enable |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_mode | input | 2 | Link mode: 00 full duplex, 01 transmit, 10 receive, 11 as 00 |
| cfg_kind | input | 2 | Transfer kind: 00 single, 01 burst, 1x continuous |
| cfg_blen | input | 4 | Burst length minus one |
| cfg_cs | input | 2 | Index of the chip select to drive |
| tx_wr | input | 1 | One-cycle pulse: transmit data written |
| frame_done | input | 1 | One-cycle pulse from the shifter: frame complete |
| frame_start | output | 1 | One-cycle pulse: launch a frame |
| cs_n | output | 4 | Active-low chip selects |
| line_idle | output | 1 | Force serial clock and transmit line to rest |
| cfg_busy | output | 1 | Settings write in progress |

## Verification
The assertions check the following on every cycle:
- An open frame is never cut short while the peripheral is enabled.
- A disabled peripheral reaches idle after one edge.
- The launch strobe lasts one cycle.
- The chip selects are one-hot-or-none and at rest whenever the lines are idle.
- The settings do not move while the busy flag is up.
- A final burst frame always leads to idle.

Only the directed scenarios can show the following:
- That the data-written event and the enable may come in either order.
- That a burst cut short gives a full burst again when re-enabled.
- That a continuous stream waits for data.
- That writes that are ignored leave the chip-select index as it was.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int CS_NUM = 4;
    localparam int CS_W   = $clog2(CS_NUM);
    localparam int BLEN_W = 4;

    typedef enum logic [1:0] {
        MODE_FDX = 2'b00,
        MODE_TX  = 2'b01,
        MODE_RX  = 2'b10,
        MODE_ALT = 2'b11
    } link_mode_e;

    typedef enum logic [1:0] {
        KIND_SINGLE = 2'b00,
        KIND_BURST  = 2'b01,
        KIND_CONT   = 2'b10,
        KIND_CONT2  = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_e;

    typedef struct packed {
        link_mode_e        mode;
        xfer_kind_e        kind;
        logic [BLEN_W-1:0] blen;
        logic [CS_W-1:0]   cs_sel;
    } seq_cfg_t;

endpackage

// File: rtl/spi_seq_cfg.sv
module spi_seq_cfg
    import spi_seq_pkg::*;
#(
    parameter int MIN_BUSY = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     periph_en,
    input  logic     cfg_wr,
    input  seq_cfg_t cfg_in,
    input  logic     seq_idle,
    output seq_cfg_t cfg_q,
    output logic     busy
);
    localparam int HW = $clog2(MIN_BUSY + 1);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '{mode: MODE_FDX, kind: KIND_SINGLE, blen: '0, cs_sel: '0};
            busy   <= 1'b0;
            hold_q <= '0;
        end else if (!periph_en) begin
            busy   <= 1'b0;
            hold_q <= '0;
        end else if (cfg_wr && !busy) begin
            cfg_q  <= cfg_in;
            busy   <= 1'b1;
            hold_q <= HW'(MIN_BUSY - 1);
        end else if (busy) begin
            if (hold_q != '0)
                hold_q <= hold_q - 1'b1;
            else if (seq_idle)
                busy <= 1'b0;
        end
    end

    AST_BUSY_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !periph_en)
        $rose(busy) |=> busy); // R3

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q)); // R2

    AST_CFG_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/spi_seq_frm_cnt.sv
module spi_seq_frm_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == len);

    AST_BURST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && last) |=> clr); // R8

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
    import spi_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       periph_en,
    input  logic       xfer_en,
    input  logic       tx_wr,
    input  logic       frame_done,
    input  link_mode_e mode,
    input  xfer_kind_e kind,
    input  logic       last_frame,
    output logic       seq_idle,
    output logic       frame_start,
    output logic       cs_act,
    output logic       line_idle,
    output logic       cnt_inc,
    output logic       cnt_clr
);
    seq_state_e state_q, state_d;
    logic       tx_pend_q;
    logic       needs_data;
    logic       ready;

    assign needs_data = (mode != MODE_RX);
    assign ready      = !needs_data || tx_pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_pend_q <= 1'b0;
        else if (!periph_en)
            tx_pend_q <= 1'b0;
        else
            tx_pend_q <= tx_wr || (tx_pend_q && !(state_q == ST_LAUNCH && needs_data));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (xfer_en && ready) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (frame_done) begin
                    unique case (kind)
                        KIND_SINGLE: state_d = ST_IDLE;
                        KIND_BURST:  state_d = (last_frame || !xfer_en) ? ST_IDLE : ST_HOLD;
                        KIND_CONT,
                        KIND_CONT2:  state_d = xfer_en ? ST_HOLD : ST_IDLE;
                    endcase
                end
            end
            ST_HOLD: begin
                if (!xfer_en)   state_d = ST_IDLE;
                else if (ready) state_d = ST_LAUNCH;
            end
        endcase
        if (!periph_en)
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        seq_idle    = (state_q == ST_IDLE);
        line_idle   = (state_q == ST_IDLE);
        cs_act      = (state_q != ST_IDLE);
        frame_start = (state_q == ST_LAUNCH);
        cnt_clr     = (state_q == ST_IDLE);
        cnt_inc     = (state_q == ST_SHIFT) && frame_done && (kind == KIND_BURST);
    end

    AST_FRAME_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !frame_done && periph_en) |=> state_q == ST_SHIFT); // R6

    AST_OFF_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> state_q == ST_IDLE); // R11

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R13

endmodule

// File: rtl/spi_seq_cs_drv.sv
module spi_seq_cs_drv #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic         act,
    input  logic [W-1:0] sel,
    output logic [N-1:0] cs_n
);
    for (genvar g = 0; g < N; g++) begin : g_cs
        assign cs_n[g] = !(act && (sel == W'(g)));
    end
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
    import spi_seq_pkg::*;
#(
    parameter int MIN_BUSY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_en,
    input  logic              xfer_en,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_kind,
    input  logic [BLEN_W-1:0] cfg_blen,
    input  logic [CS_W-1:0]   cfg_cs,
    input  logic              tx_wr,
    input  logic              frame_done,
    output logic              frame_start,
    output logic [CS_NUM-1:0] cs_n,
    output logic              line_idle,
    output logic              cfg_busy
);
    seq_cfg_t cfg_in, cfg_q;
    logic     seq_idle, cs_act, cnt_inc, cnt_clr, last_frame;

    assign cfg_in = '{mode: link_mode_e'(cfg_mode), kind: xfer_kind_e'(cfg_kind),
                      blen: cfg_blen, cs_sel: cfg_cs};

    spi_seq_cfg #(.MIN_BUSY(MIN_BUSY)) i_cfg (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .cfg_wr(cfg_wr),
        .cfg_in(cfg_in), .seq_idle(seq_idle), .cfg_q(cfg_q), .busy(cfg_busy)
    );

    spi_seq_frm_cnt #(.W(BLEN_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .len(cfg_q.blen), .last(last_frame)
    );

    spi_seq_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .xfer_en(xfer_en),
        .tx_wr(tx_wr), .frame_done(frame_done), .mode(cfg_q.mode), .kind(cfg_q.kind),
        .last_frame(last_frame), .seq_idle(seq_idle), .frame_start(frame_start),
        .cs_act(cs_act), .line_idle(line_idle), .cnt_inc(cnt_inc), .cnt_clr(cnt_clr)
    );

    spi_seq_cs_drv #(.N(CS_NUM), .W(CS_W)) i_cs (
        .act(cs_act), .sel(cfg_q.cs_sel), .cs_n(cs_n)
    );

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R12

    AST_IDLE_LINES_REST: assert property (@(posedge clk) disable iff (!rst_n)
        line_idle |-> (&cs_n)); // R7

    AST_START_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !(&cs_n)); // R12

endmodule

// File: tb/test_spi_xfer_seq.sv
module test_spi_xfer_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_en = 1'b0, xfer_en = 1'b0, cfg_wr = 1'b0;
    logic [1:0] cfg_mode = 2'b00, cfg_kind = 2'b00, cfg_cs = 2'b00;
    logic [3:0] cfg_blen = 4'd0;
    logic       tx_wr = 1'b0, frame_done = 1'b0;
    logic       frame_start, line_idle, cfg_busy;
    logic [3:0] cs_n;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    spi_xfer_seq i_spi_xfer_seq (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .xfer_en(xfer_en),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_kind(cfg_kind), .cfg_blen(cfg_blen),
        .cfg_cs(cfg_cs), .tx_wr(tx_wr), .frame_done(frame_done),
        .frame_start(frame_start), .cs_n(cs_n), .line_idle(line_idle), .cfg_busy(cfg_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cfg(input logic [1:0] m, input logic [1:0] k,
                          input logic [3:0] bl, input logic [1:0] cs);
        tick(); cfg_mode = m; cfg_kind = k; cfg_blen = bl; cfg_cs = cs; cfg_wr = 1'b1;
        tick(); cfg_wr = 1'b0;
        tick(4);
    endtask

    task automatic pulse_tx();
        tick(); tx_wr = 1'b1;
        tick(); tx_wr = 1'b0;
    endtask

    task automatic finish_frame();
        tick(); frame_done = 1'b1;
        tick(); frame_done = 1'b0;
    endtask

    task automatic wait_start(input int max, output int found);
        found = 0;
        for (int i = 0; i < max; i++) begin
            tick();
            if (frame_start) begin found = 1; break; end
        end
    endtask

    task automatic count_starts(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            tick();
            if (frame_start) n++;
        end
    endtask

    // runs frames until the sequencer goes idle, then drops xfer_en
    task automatic run_burst(input logic [3:0] cs_exp, output int frames);
        int f;
        frames = 0;
        for (int i = 0; i < 20; i++) begin
            wait_start(6, f);
            if (f == 0) break;
            frames++;
            chk("R8 cs held in frame", cs_n, cs_exp);
            finish_frame();
            if (line_idle) begin xfer_en = 1'b0; break; end
            chk("R8 cs held between frames", cs_n, cs_exp);
        end
        xfer_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cs_n", cs_n, 4'hF);
        chk("R1 line_idle", line_idle, 1);
        chk("R1 frame_start", frame_start, 0);
        chk("R1 cfg_busy", cfg_busy, 0);
    endtask

    task automatic t_busy();
        tick(); cfg_mode = 2'b00; cfg_kind = 2'b00; cfg_cs = 2'd1; cfg_wr = 1'b1;
        tick(); chk("R3 busy cycle 1", cfg_busy, 1);
        cfg_cs = 2'd3;                       // R2: ignored, busy
        tick(); chk("R3 busy cycle 2", cfg_busy, 1);
        cfg_wr = 1'b0;
        tick(); chk("R3 busy clears when idle", cfg_busy, 0);
    endtask

    task automatic t_data_first();
        int n;
        pulse_tx();
        tick(); xfer_en = 1'b1;
        tick(); chk("R4 start one cycle after enable", frame_start, 1);
        chk("R2 ignored write kept cs 1", cs_n, 4'b1101);
        tick(); chk("R13 start is one cycle", frame_start, 0);
        xfer_en = 1'b0;
        tick(3);
        chk("R6 cs held after enable cleared", cs_n, 4'b1101);
        chk("R6 lines not idle mid-frame", line_idle, 0);
        finish_frame();
        chk("R7 cs at rest after stop", cs_n, 4'hF);
        chk("R7 line_idle after stop", line_idle, 1);
        count_starts(4, n);
        chk("R7 no start after stop", n, 0);
    endtask

    task automatic t_enable_first();
        int n, f;
        tick(); xfer_en = 1'b1;
        count_starts(4, n);
        chk("R4 no start without data", n, 0);
        pulse_tx();
        wait_start(4, f);
        chk("R4 start after late data write", f, 1);
        xfer_en = 1'b0;
        finish_frame();
        chk("R7 idle after late-data frame", line_idle, 1);
    endtask

    task automatic t_rx();
        int f;
        do_cfg(2'b10, 2'b00, 4'd0, 2'd0);
        tick(); xfer_en = 1'b1;
        tick(); chk("R5 receive starts without data", frame_start, 1);
        chk("R12 cs 0 selected", cs_n, 4'b1110);
        xfer_en = 1'b0;
        finish_frame();
        chk("R5 idle after receive frame", line_idle, 1);
        f = 0;
    endtask

    task automatic t_burst();
        int fr;
        do_cfg(2'b10, 2'b01, 4'd2, 2'd2);
        tick(); xfer_en = 1'b1;
        run_burst(4'b1011, fr);
        chk("R8 burst L=2 gives 3 frames", fr, 3);
        tick();
        chk("R8 idle after burst", line_idle, 1);
    endtask

    task automatic t_burst_restart();
        int f, fr;
        do_cfg(2'b10, 2'b01, 4'd3, 2'd2);
        tick(); xfer_en = 1'b1;
        wait_start(4, f);
        finish_frame();
        wait_start(4, f);
        chk("R9 second frame started", f, 1);
        xfer_en = 1'b0;
        finish_frame();
        chk("R9 stopped mid-burst is idle", line_idle, 1);
        tick(2);
        xfer_en = 1'b1;
        run_burst(4'b1011, fr);
        chk("R9 restarted burst gives 4 frames", fr, 4);
    endtask

    task automatic t_cont();
        int f, n;
        do_cfg(2'b01, 2'b10, 4'd0, 2'd0);
        pulse_tx();
        tick(); xfer_en = 1'b1;
        wait_start(4, f);
        chk("R10 first continuous frame", f, 1);
        finish_frame();
        chk("R10 cs held while waiting", cs_n, 4'b1110);
        chk("R10 lines active while waiting", line_idle, 0);
        count_starts(4, n);
        chk("R10 no frame without data", n, 0);
        pulse_tx();
        wait_start(4, f);
        chk("R10 frame after new data", f, 1);
        pulse_tx();
        finish_frame();
        wait_start(4, f);
        chk("R10 back-to-back with data ready", f, 1);
        xfer_en = 1'b0;
        finish_frame();
        chk("R10 stop ends continuous stream", line_idle, 1);
    endtask

    task automatic t_periph_off();
        int f, n;
        do_cfg(2'b01, 2'b00, 4'd0, 2'd0);
        pulse_tx();
        tick(); xfer_en = 1'b1;
        wait_start(4, f);
        tick(); periph_en = 1'b0;
        tick();
        chk("R11 idle one edge after disable", line_idle, 1);
        chk("R11 cs released on disable", cs_n, 4'hF);
        xfer_en = 1'b0;
        cfg_cs = 2'd3; cfg_wr = 1'b1;        // R2: ignored while disabled
        tick(); cfg_wr = 1'b0;
        periph_en = 1'b1;
        pulse_tx();
        tick(); periph_en = 1'b0;
        tick(); periph_en = 1'b1;
        tick(); xfer_en = 1'b1;
        count_starts(5, n);
        chk("R11 pending data discarded", n, 0);
        pulse_tx();
        wait_start(4, f);
        chk("R2 write while disabled ignored", cs_n, 4'b1110);
        xfer_en = 1'b0;
        finish_frame();
    endtask

    task automatic t_stray_done();
        int n;
        finish_frame();
        chk("R13 stray done keeps idle", line_idle, 1);
        count_starts(3, n);
        chk("R13 stray done starts nothing", n, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick();
        periph_en = 1'b1;
        tick();
        t_busy();
        t_data_first();
        t_enable_first();
        t_rx();
        t_burst();
        t_burst_restart();
        t_cont();
        t_periph_off();
        t_stray_done();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule